// File: doc/BRIEF.md
# Delayed Branch Program Counter Sequencer

This block holds the fetch program counter of a pipelined processor front end and decides when it moves. It handles two kinds of control transfer. A standard transfer covers branches, calls, returns, traps and repeats. It drains the pipeline with a flush window and then loads the target. A delayed transfer can be conditional. It lets a fixed number of following instructions (the delay slots, three by default) complete first, and then loads the target in place of the next sequential address, so no cycles are lost.

The condition of a delayed transfer is resolved when the transfer completes, from the flag register as it stood after the instruction before it. Flag writes made by the slot instructions cannot change the outcome. Interrupts are held off while slots are outstanding. A request that arrives in that window is remembered and honoured as soon as the window closes. A control transfer or halt placed inside the slots raises a sticky error flag, which only a reset clears.

Instruction decode is done upstream. Each completing instruction is presented as a 2-bit class token with a valid strobe. A stall input holds completion back without cancelling any pending slot.

Top module: `pcs_seq`

## Requirements
- R1: With no transfer pending, every completion (instr_valid=1, stall=0, flush_o=0) of a class 0 (plain) or class 3 (halt) instruction advances pc_o by one on the next cycle. A cycle without a completion leaves pc_o unchanged.
- R2: A class 2 (delayed) instruction completing outside the slots advances pc_o by one and never raises flush_o. The third completion after it loads pc_o with the target latched at acceptance when the branch is taken, and with no stall that happens three cycles after acceptance.
- R3: A class 1 (standard) instruction completing outside the slots raises flush_o for the next three cycles with pc_o held. Completions offered during those cycles are ignored. pc_o equals the latched target four cycles after acceptance, and flush_o is low again at that point.
- R4: The condition of a delayed instruction is instr_cond, sampled at acceptance. If its top bit is 1 the branch is always taken. Otherwise it is taken when the flag bit indexed by the low bits is 1, reading the flags as they stood before the branch completed. Flag writes by slot instructions do not change the decision.
- R5: The flag register loads flag_in only on a completion with flag_we=1. Otherwise it keeps its value.
- R6: int_en_o is low from the cycle after a delayed instruction is accepted until its third slot completes. This holds whether or not the branch is taken.
- R7: A class 1, 2 or 3 instruction completing while slots are outstanding sets slot_err_o. slot_err_o stays set until reset.
- R8: A stall (stall=1) prevents completion. The slot count and pc_o stay unchanged, and the slots still all complete afterwards.
- R9: A synchronous reset (rst=1) sets pc_o to zero and clears flush_o, slot_err_o, pending slots and any held interrupt, leaving int_en_o high.
- R10: An irq_req pulse arriving while int_en_o is low is held. irq_take_o stays low while int_en_o is low and is high on the first cycle int_en_o is high again. It drops on the following cycle.
- R11: A delayed instruction that is not taken lets pc_o continue by one per completion after its slots, exactly as plain code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | An instruction completes this cycle |
| stall | input | 1 | Pipeline stall, blocks completion |
| instr_class | input | 2 | 0 plain, 1 standard transfer, 2 delayed transfer, 3 halt |
| instr_cond | input | CSEL_W | Condition: top bit always-taken, low bits flag index |
| br_target | input | PC_W | Transfer target address |
| flag_in | input | FLAG_W | New flag value |
| flag_we | input | 1 | Completing instruction writes the flags |
| irq_req | input | 1 | Interrupt request |
| pc_o | output | PC_W | Fetch program counter |
| flush_o | output | 1 | Pipeline flush in progress |
| int_en_o | output | 1 | Interrupts allowed |
| irq_take_o | output | 1 | Interrupt honoured this cycle |
| slot_err_o | output | 1 | Sticky illegal-slot error |

## Verification
The delayed path is tried as always-taken, as flag-taken and as flag-not-taken. In the flag cases the slot instructions write the opposite flag value, which separates decisions latched at acceptance from decisions made late. One case writes flag_in with flag_we low before the branch, and its outcome shows whether the flag register ignored that write. A standard transfer is offered with completions arriving during the flush, which shows whether those completions are discarded. Stalls inside the slots, an interrupt pulse inside the window and a forbidden class inside a slot exercise the remaining corner cases.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
   typedef enum logic [1:0] {
      CL_PLAIN = 2'd0,
      CL_STDBR = 2'd1,
      CL_DLYBR = 2'd2,
      CL_HALT  = 2'd3
   } instr_cls_e;
endpackage

// File: rtl/pcs_flag_reg.sv
module pcs_flag_reg #(
   parameter int FLAG_W = 4,
   localparam int IDX_W = $clog2(FLAG_W),
   localparam int CSEL_W = IDX_W + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [FLAG_W-1:0] wr_data,
   input  logic [CSEL_W-1:0] cond_sel,
   output logic              cond_true
);
   logic [FLAG_W-1:0] flags_q;

   always_ff @(posedge clk) begin
      if (rst)        flags_q <= '0;
      else if (wr_en) flags_q <= wr_data;
   end

   // top bit selects the unconditional form
   assign cond_true = cond_sel[CSEL_W-1] | flags_q[cond_sel[IDX_W-1:0]];
endmodule

// File: rtl/pcs_slot_ctrl.sv
module pcs_slot_ctrl
   import pcs_pkg::*;
#(
   parameter int PC_W = 16,
   parameter int SLOTS = 3,
   parameter bit SLOT_CHECK = 1'b1,
   localparam int SCNT_W = $clog2(SLOTS + 1)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            done,
   input  instr_cls_e      cls,
   input  logic            cond_true,
   input  logic [PC_W-1:0] target,
   output logic            busy,
   output logic            redirect,
   output logic [PC_W-1:0] tgt,
   output logic            err
);
   logic [SCNT_W-1:0] cnt_q;
   logic              taken_q;
   logic [PC_W-1:0]   tgt_q;
   logic              accept;
   logic              slot_done;

   assign busy      = (cnt_q != '0);
   assign accept    = done && !busy && (cls == CL_DLYBR);
   assign slot_done = done && busy;
   assign redirect  = slot_done && (cnt_q == SCNT_W'(1)) && taken_q;
   assign tgt       = tgt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q   <= '0;
         taken_q <= 1'b0;
         tgt_q   <= '0;
      end else if (accept) begin
         cnt_q   <= SCNT_W'(SLOTS);
         taken_q <= cond_true;
         tgt_q   <= target;
      end else if (slot_done) begin
         cnt_q   <= cnt_q - SCNT_W'(1);
      end
   end

   generate
      if (SLOT_CHECK) begin : g_chk
         logic err_q;
         always_ff @(posedge clk) begin
            if (rst)                                err_q <= 1'b0;
            else if (slot_done && cls != CL_PLAIN)  err_q <= 1'b1;
         end
         assign err = err_q;
      end else begin : g_nochk
         assign err = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/pcs_flush_ctrl.sv
module pcs_flush_ctrl #(
   parameter int PC_W = 16,
   parameter int FLUSH_CYC = 4,
   localparam int FCNT_W = $clog2(FLUSH_CYC)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            start,
   input  logic [PC_W-1:0] target,
   output logic            busy,
   output logic            redirect,
   output logic [PC_W-1:0] tgt
);
   logic              busy_q;
   logic [FCNT_W-1:0] cnt_q;
   logic [PC_W-1:0]   tgt_q;

   assign busy     = busy_q;
   assign redirect = busy_q && (cnt_q == FCNT_W'(1));
   assign tgt      = tgt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         tgt_q  <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         cnt_q  <= FCNT_W'(FLUSH_CYC - 1);
         tgt_q  <= target;
      end else if (busy_q) begin
         if (cnt_q == FCNT_W'(1)) busy_q <= 1'b0;
         cnt_q <= cnt_q - FCNT_W'(1);
      end
   end
endmodule

// File: rtl/pcs_irq_gate.sv
module pcs_irq_gate (
   input  logic clk,
   input  logic rst,
   input  logic open,
   input  logic irq_req,
   output logic irq_take
);
   logic pend_q;

   assign irq_take = open && (pend_q || irq_req);

   always_ff @(posedge clk) begin
      if (rst) pend_q <= 1'b0;
      else     pend_q <= (pend_q || irq_req) && !irq_take;
   end
endmodule

// File: rtl/pcs_seq.sv
module pcs_seq
   import pcs_pkg::*;
#(
   parameter int PC_W = 16,
   parameter int FLAG_W = 4,
   parameter int SLOTS = 3,
   parameter int FLUSH_CYC = 4,
   parameter bit SLOT_CHECK = 1'b1,
   localparam int CSEL_W = $clog2(FLAG_W) + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              instr_valid,
   input  logic              stall,
   input  logic [1:0]        instr_class,
   input  logic [CSEL_W-1:0] instr_cond,
   input  logic [PC_W-1:0]   br_target,
   input  logic [FLAG_W-1:0] flag_in,
   input  logic              flag_we,
   input  logic              irq_req,
   output logic [PC_W-1:0]   pc_o,
   output logic              flush_o,
   output logic              int_en_o,
   output logic              irq_take_o,
   output logic              slot_err_o
);
   generate
      if (PC_W < 2) begin : g_bad_pc
         $error("pcs_seq: PC_W must be at least 2");
      end
      if (FLAG_W < 2 || (FLAG_W & (FLAG_W - 1)) != 0) begin : g_bad_flag
         $error("pcs_seq: FLAG_W must be a power of two, at least 2");
      end
      if (SLOTS < 1) begin : g_bad_slots
         $error("pcs_seq: SLOTS must be at least 1");
      end
      if (FLUSH_CYC < 2) begin : g_bad_flush
         $error("pcs_seq: FLUSH_CYC must be at least 2");
      end
   endgenerate

   instr_cls_e      cls;
   logic            done;
   logic            cond_true;
   logic            slot_busy, slot_redir, fl_busy, fl_redir, std_start;
   logic [PC_W-1:0] slot_tgt, fl_tgt, pc_q;

   assign cls       = instr_cls_e'(instr_class);
   assign done      = instr_valid && !stall && !fl_busy;
   assign std_start = done && !slot_busy && (cls == CL_STDBR);

   pcs_flag_reg #(.FLAG_W(FLAG_W)) u_flags (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (done && flag_we),
      .wr_data   (flag_in),
      .cond_sel  (instr_cond),
      .cond_true (cond_true)
   );

   pcs_slot_ctrl #(.PC_W(PC_W), .SLOTS(SLOTS), .SLOT_CHECK(SLOT_CHECK)) u_slots (
      .clk       (clk),
      .rst       (rst),
      .done      (done),
      .cls       (cls),
      .cond_true (cond_true),
      .target    (br_target),
      .busy      (slot_busy),
      .redirect  (slot_redir),
      .tgt       (slot_tgt),
      .err       (slot_err_o)
   );

   pcs_flush_ctrl #(.PC_W(PC_W), .FLUSH_CYC(FLUSH_CYC)) u_flush (
      .clk      (clk),
      .rst      (rst),
      .start    (std_start),
      .target   (br_target),
      .busy     (fl_busy),
      .redirect (fl_redir),
      .tgt      (fl_tgt)
   );

   pcs_irq_gate u_irq (
      .clk      (clk),
      .rst      (rst),
      .open     (!slot_busy),
      .irq_req  (irq_req),
      .irq_take (irq_take_o)
   );

   always_ff @(posedge clk) begin
      if (rst)             pc_q <= '0;
      else if (fl_redir)   pc_q <= fl_tgt;
      else if (done) begin
         if (slot_redir)     pc_q <= slot_tgt;
         else if (!std_start) pc_q <= pc_q + PC_W'(1);
      end
   end

   assign pc_o     = pc_q;
   assign flush_o  = fl_busy;
   assign int_en_o = !slot_busy;
endmodule

// File: rtl/pcs_seq_chk.sv
module pcs_seq_chk #(
   parameter int PC_W = 16,
   parameter int CSEL_W = 3
) (
   input logic              clk,
   input logic              rst,
   input logic              instr_valid,
   input logic              stall,
   input logic [1:0]        instr_class,
   input logic [CSEL_W-1:0] instr_cond,
   input logic [PC_W-1:0]   pc_o,
   input logic              flush_o,
   input logic              int_en_o,
   input logic              irq_take_o,
   input logic              slot_err_o
);
   logic done;
   assign done = instr_valid && !stall && !flush_o;

   AST_PLAIN_STEP: assert property (@(posedge clk) disable iff (rst)
      done && instr_class == 2'd0 && int_en_o |=> pc_o == $past(pc_o) + PC_W'(1)); // R1
   AST_STD_FLUSH: assert property (@(posedge clk) disable iff (rst)
      done && instr_class == 2'd1 && int_en_o |=> flush_o); // R3
   AST_FLUSH_HOLD: assert property (@(posedge clk) disable iff (rst)
      flush_o && $past(flush_o) |-> $stable(pc_o)); // R3
   AST_DLY_MASK: assert property (@(posedge clk) disable iff (rst)
      done && instr_class == 2'd2 && int_en_o |=> !int_en_o && !flush_o); // R6
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
      slot_err_o |=> slot_err_o); // R7
   AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (rst)
      stall && !flush_o |=> $stable(pc_o) && $stable(int_en_o)); // R8
   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
      irq_take_o |-> int_en_o); // R10
   AST_COND_KNOWN: assert property (@(posedge clk) disable iff (rst)
      instr_valid |-> !$isunknown(instr_cond)); // R4
endmodule

bind pcs_seq pcs_seq_chk #(.PC_W(PC_W), .CSEL_W(CSEL_W)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .instr_valid (instr_valid),
   .stall       (stall),
   .instr_class (instr_class),
   .instr_cond  (instr_cond),
   .pc_o        (pc_o),
   .flush_o     (flush_o),
   .int_en_o    (int_en_o),
   .irq_take_o  (irq_take_o),
   .slot_err_o  (slot_err_o)
);

// File: tb/tb_pcs_seq.sv
module tb_pcs_seq;
   localparam int CLK_PERIOD = 10;
   localparam int PC_W = 16;
   localparam int FLAG_W = 4;
   localparam int CSEL_W = $clog2(FLAG_W) + 1;
   localparam logic [CSEL_W-1:0] C_ALWAYS = 3'b100;

   logic clk = 1'b0;
   logic rst, instr_valid, stall, flag_we, irq_req;
   logic [1:0] instr_class;
   logic [CSEL_W-1:0] instr_cond;
   logic [PC_W-1:0] br_target;
   logic [FLAG_W-1:0] flag_in;
   logic [PC_W-1:0] pc_o;
   logic flush_o, int_en_o, irq_take_o, slot_err_o;

   int n_run = 0;
   int n_fail = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   pcs_seq dut (
      .clk(clk), .rst(rst), .instr_valid(instr_valid), .stall(stall),
      .instr_class(instr_class), .instr_cond(instr_cond), .br_target(br_target),
      .flag_in(flag_in), .flag_we(flag_we), .irq_req(irq_req),
      .pc_o(pc_o), .flush_o(flush_o), .int_en_o(int_en_o),
      .irq_take_o(irq_take_o), .slot_err_o(slot_err_o)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic idle_in();
      instr_valid = 1'b0; stall = 1'b0; instr_class = 2'd0; instr_cond = '0;
      br_target = '0; flag_in = '0; flag_we = 1'b0; irq_req = 1'b0;
   endtask

   // drive one instruction for one cycle, return at the next negedge
   task automatic step(input logic [1:0] cls, input logic [CSEL_W-1:0] cnd,
                       input int tgt, input logic fwe, input logic [FLAG_W-1:0] fin);
      instr_valid = 1'b1; stall = 1'b0; instr_class = cls; instr_cond = cnd;
      br_target = PC_W'(tgt); flag_we = fwe; flag_in = fin;
      @(negedge clk);
      idle_in();
   endtask

   task automatic plain();
      step(2'd0, '0, 0, 1'b0, '0);
   endtask

   task automatic do_reset();
      idle_in();
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R9", "pc", int'(pc_o), 0);
      chk("R9", "flush", int'(flush_o), 0);
      chk("R9", "int_en", int'(int_en_o), 1);
      chk("R9", "err", int'(slot_err_o), 0);
      chk("R9", "irq_take", int'(irq_take_o), 0);
   endtask

   task automatic t_plain();
      int p = int'(pc_o);
      plain(); plain(); step(2'd3, '0, 0, 1'b0, '0);
      chk("R1", "pc after three", int'(pc_o), p + 3);
      @(negedge clk);
      chk("R1", "pc idle", int'(pc_o), p + 3);
      instr_valid = 1'b1; stall = 1'b1;
      @(negedge clk);
      idle_in();
      chk("R8", "pc stalled", int'(pc_o), p + 3);
   endtask

   task automatic t_dly_taken();
      int p = int'(pc_o);
      step(2'd2, C_ALWAYS, 16'h0100, 1'b0, '0);
      chk("R2", "pc after accept", int'(pc_o), p + 1);
      chk("R2", "no flush", int'(flush_o), 0);
      chk("R6", "masked", int'(int_en_o), 0);
      plain(); plain();
      chk("R2", "pc slot2", int'(pc_o), p + 3);
      chk("R6", "masked slot2", int'(int_en_o), 0);
      plain();
      chk("R2", "pc target", int'(pc_o), 16'h0100);
      chk("R6", "unmasked", int'(int_en_o), 1);
   endtask

   task automatic t_dly_cond();
      int p;
      step(2'd0, '0, 0, 1'b1, 4'b0001);
      step(2'd2, 3'b000, 16'h0240, 1'b0, '0);
      step(2'd0, '0, 0, 1'b1, 4'b0000);
      plain(); plain();
      chk("R4", "flag taken despite slot write", int'(pc_o), 16'h0240);
      p = int'(pc_o);
      step(2'd2, 3'b001, 16'h0500, 1'b0, '0);
      step(2'd0, '0, 0, 1'b1, 4'b1111);
      plain();
      chk("R6", "masked not-taken", int'(int_en_o), 0);
      plain();
      chk("R11", "not taken pc", int'(pc_o), p + 4);
      chk("R6", "unmasked not-taken", int'(int_en_o), 1);
      plain();
      chk("R11", "sequential after", int'(pc_o), p + 5);
   endtask

   task automatic t_flag_we();
      int p;
      step(2'd0, '0, 0, 1'b1, 4'b0000);
      step(2'd0, '0, 0, 1'b0, 4'b1111);
      p = int'(pc_o);
      step(2'd2, 3'b010, 16'h0700, 1'b0, '0);
      plain(); plain(); plain();
      chk("R5", "write without strobe ignored", int'(pc_o), p + 4);
   endtask

   task automatic t_std();
      int p = int'(pc_o);
      step(2'd1, '0, 16'h0200, 1'b0, '0);
      chk("R3", "flush c1", int'(flush_o), 1);
      chk("R3", "pc held c1", int'(pc_o), p);
      plain();
      chk("R3", "flush c2", int'(flush_o), 1);
      plain();
      chk("R3", "flush c3", int'(flush_o), 1);
      chk("R3", "pc held c3", int'(pc_o), p);
      plain();
      chk("R3", "pc target c4", int'(pc_o), 16'h0200);
      chk("R3", "flush done", int'(flush_o), 0);
      chk("R3", "interrupts open", int'(int_en_o), 1);
   endtask

   task automatic t_stall_slots();
      int p = int'(pc_o);
      step(2'd2, C_ALWAYS, 16'h0300, 1'b0, '0);
      plain();
      instr_valid = 1'b1; stall = 1'b1;
      @(negedge clk); @(negedge clk);
      idle_in();
      chk("R8", "pc frozen in slots", int'(pc_o), p + 2);
      chk("R8", "still masked", int'(int_en_o), 0);
      plain();
      chk("R8", "pc slot2", int'(pc_o), p + 3);
      plain();
      chk("R8", "target after stalled slots", int'(pc_o), 16'h0300);
   endtask

   task automatic t_irq();
      step(2'd2, 3'b011, 16'h0900, 1'b0, '0);
      instr_valid = 1'b1; irq_req = 1'b1;
      @(negedge clk);
      idle_in();
      chk("R10", "no take in window", int'(irq_take_o), 0);
      plain();
      chk("R10", "no take slot2", int'(irq_take_o), 0);
      plain();
      chk("R10", "take after window", int'(irq_take_o), 1);
      @(negedge clk);
      chk("R10", "take drops", int'(irq_take_o), 0);
   endtask

   task automatic t_illegal();
      step(2'd2, C_ALWAYS, 16'h0a00, 1'b0, '0);
      chk("R7", "no err before", int'(slot_err_o), 0);
      step(2'd1, '0, 16'h0b00, 1'b0, '0);
      chk("R7", "err raised", int'(slot_err_o), 1);
      plain(); plain(); plain();
      chk("R7", "err sticky", int'(slot_err_o), 1);
      do_reset();
      chk("R9", "err cleared", int'(slot_err_o), 0);
      chk("R9", "pc cleared", int'(pc_o), 0);
      chk("R9", "int_en after reset", int'(int_en_o), 1);
   endtask

   initial begin
      idle_in();
      rst = 1'b1;
      @(negedge clk);
      t_reset();
      t_plain();
      t_dly_taken();
      t_dly_cond();
      t_flag_we();
      t_std();
      t_stall_slots();
      t_irq();
      t_illegal();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule